// File: doc/BRIEF.md
# CAN Controller Register Access Window

This block lets an 8-bit microcontroller reach the 256-byte internal register space of a CAN controller through a handful of special-function-register (SFR) addresses. On the SFR side it sees an address, read and write strobes and write data, and it returns read data in the same cycle. On the controller side it drives an internal register address, read and write strobes and write data, and it takes back the controller's read data.

Two of the SFR addresses form an indirect path. One is a pointer that holds an internal address. The other is a data port that reads or writes whatever register the pointer selects. In the upper part of the space, from address 32 up, the pointer advances by one after each data-port access. A block of bytes, such as a transmit message starting at internal address 112, can therefore be streamed through the data port. Below 32 the pointer stays where it is, so a low register can be polled over and over.

The other three SFR addresses are fixed windows onto low internal registers. One window reaches the mode register at internal address 0 in both directions. The other two select a different internal register for reads than for writes.

Top module: `can_sfr_window`

## Requirements
- R1: After reset the pointer holds 00h, and a read of the pointer window returns 00h.
- R2: A write to the pointer window loads the pointer with the write data, and a read of the pointer window returns the pointer. Neither access raises a controller-side strobe.
- R3: A data-port access drives the pointer value as the controller address and raises exactly one single-cycle controller strobe of the same direction. A write passes the SFR write data through. A read returns the controller read data on the SFR read data in the same cycle.
- R4: When the pointer is 32 or higher, each data-port access increments it by one on the clock edge that ends the access, so the next access uses the new address.
- R5: When the pointer is below 32, data-port accesses leave it unchanged, so repeated accesses hit the same internal address.
- R6: A data-port access with the pointer at FFh wraps it to 00h.
- R7: Mode window reads and writes both target internal address 0.
- R8: Status window reads target internal address 2. Status window writes target internal address 4.
- R9: Control window reads target internal address 3. Control window writes target internal address 1.
- R10: Accesses through the mode, status and control windows never change the pointer.
- R11: An SFR access to any address outside the five windows raises no controller strobe, leaves the pointer unchanged and returns 00h.
- R12: If read and write are asserted together, the access is a write. Only the controller write strobe rises, and a data-port access advances the pointer at most once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; deassertion synchronised internally |
| sfr_addr | input | 8 | SFR address of the current access |
| sfr_rd | input | 1 | SFR read strobe, one cycle per access |
| sfr_wr | input | 1 | SFR write strobe, one cycle per access |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data, valid in the cycle of the read strobe |
| ctl_addr | output | 8 | Internal register address toward the controller |
| ctl_rd | output | 1 | Controller register read strobe |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_wdata | output | 8 | Controller register write data |
| ctl_rdata | input | 8 | Controller register read data |

## Verification
The embedded assertions check on every cycle that controller strobes are mutually exclusive and occur only for mapped addresses. They also check that the three fixed windows land on their internal addresses in each direction, and that the pointer steps above the threshold, holds below it and holds when there is no data-port access. Only the bench scenarios can show that the pointer value reads back correctly and that read data returns from the controller. The same holds for the streamed message load landing on consecutive addresses, the FFh wrap seen from the SFR side, and the effect of a combined read and write strobe on later accesses.

// File: rtl/can_sfr_pkg.sv
package can_sfr_pkg;

  typedef enum logic [2:0] {
    WIN_NONE = 3'd0,
    WIN_PTR  = 3'd1,
    WIN_DATA = 3'd2,
    WIN_MODE = 3'd3,
    WIN_STAT = 3'd4,
    WIN_CTRL = 3'd5
  } win_e;

  // Internal register addresses reached by the fixed windows
  localparam int IREG_MODE   = 0;
  localparam int IREG_CMD    = 1;
  localparam int IREG_STATUS = 2;
  localparam int IREG_IRQ    = 3;
  localparam int IREG_IEN    = 4;

endpackage

// File: rtl/can_sfr_decode.sv
module can_sfr_decode
  import can_sfr_pkg::*;
#(
  parameter int          SFR_AW   = 8,
  parameter logic [7:0]  ADR_PTR  = 8'hD0,
  parameter logic [7:0]  ADR_DATA = 8'hD1,
  parameter logic [7:0]  ADR_MODE = 8'hD2,
  parameter logic [7:0]  ADR_STAT = 8'hD3,
  parameter logic [7:0]  ADR_CTRL = 8'hD4
) (
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_rd,
  input  logic              sfr_wr,
  output win_e              win,
  output logic              acc_rd,
  output logic              acc_wr
);

  logic hit;

  always_comb begin
    win = WIN_NONE;
    if (sfr_addr == SFR_AW'(ADR_PTR))       win = WIN_PTR;
    else if (sfr_addr == SFR_AW'(ADR_DATA)) win = WIN_DATA;
    else if (sfr_addr == SFR_AW'(ADR_MODE)) win = WIN_MODE;
    else if (sfr_addr == SFR_AW'(ADR_STAT)) win = WIN_STAT;
    else if (sfr_addr == SFR_AW'(ADR_CTRL)) win = WIN_CTRL;
  end

  assign hit    = (win != WIN_NONE);
  // write has priority when both strobes are present
  assign acc_wr = sfr_wr & hit;
  assign acc_rd = sfr_rd & ~sfr_wr & hit;

endmodule

// File: rtl/can_sfr_pointer.sv
module can_sfr_pointer #(
  parameter int AW       = 8,
  parameter int INC_BASE = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  output logic [AW-1:0] ptr
);

  localparam logic [AW-1:0] BaseV = INC_BASE[AW-1:0];

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nxt;
  logic          upper;
  logic          ptr_en;

  assign upper  = (ptr_q >= BaseV);
  assign ptr_en = load_en | (step_en & upper);

  always_comb begin
    ptr_nxt = ptr_q;
    if (load_en)
      ptr_nxt = load_val;
    else if (step_en && upper)
      ptr_nxt = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (ptr_en)
      ptr_q <= ptr_nxt;
  end

  assign ptr = ptr_q;

  AST_PTR_STEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && ptr_q >= BaseV) |=> (ptr_q == $past(ptr_q) + 1'b1)); // R4
  AST_PTR_HOLD_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && ptr_q < BaseV) |=> $stable(ptr_q)); // R5
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && ptr_q == {AW{1'b1}}) |=> (ptr_q == '0)); // R6
  AST_PTR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> $stable(ptr_q)); // R10

endmodule

// File: rtl/can_sfr_route.sv
module can_sfr_route
  import can_sfr_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  win_e          win,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] ctl_rdata,
  output logic [AW-1:0] ctl_addr,
  output logic          ctl_rd,
  output logic          ctl_wr,
  output logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] sfr_rdata
);

  logic to_ctl;

  // every window except the pointer reaches the controller
  assign to_ctl = (win != WIN_NONE) && (win != WIN_PTR);

  always_comb begin
    ctl_addr = '0;
    unique case (win)
      WIN_DATA: ctl_addr = ptr;
      WIN_MODE: ctl_addr = AW'(IREG_MODE);
      WIN_STAT: ctl_addr = acc_wr ? AW'(IREG_IEN) : AW'(IREG_STATUS);
      WIN_CTRL: ctl_addr = acc_wr ? AW'(IREG_CMD) : AW'(IREG_IRQ);
      default:  ctl_addr = '0;
    endcase
  end

  assign ctl_rd    = to_ctl & acc_rd;
  assign ctl_wr    = to_ctl & acc_wr;
  assign ctl_wdata = acc_wr ? sfr_wdata : '0;

  always_comb begin
    sfr_rdata = '0;
    if (acc_rd) begin
      if (win == WIN_PTR)
        sfr_rdata = DW'(ptr);
      else if (to_ctl)
        sfr_rdata = ctl_rdata;
    end
  end

endmodule

// File: rtl/can_sfr_window.sv
module can_sfr_window
  import can_sfr_pkg::*;
#(
  parameter int         AW       = 8,
  parameter int         DW       = 8,
  parameter int         SFR_AW   = 8,
  parameter int         INC_BASE = 32,
  parameter logic [7:0] ADR_PTR  = 8'hD0,
  parameter logic [7:0] ADR_DATA = 8'hD1,
  parameter logic [7:0] ADR_MODE = 8'hD2,
  parameter logic [7:0] ADR_STAT = 8'hD3,
  parameter logic [7:0] ADR_CTRL = 8'hD4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SFR_AW-1:0] sfr_addr,
  input  logic              sfr_rd,
  input  logic              sfr_wr,
  input  logic [DW-1:0]     sfr_wdata,
  output logic [DW-1:0]     sfr_rdata,
  output logic [AW-1:0]     ctl_addr,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic [DW-1:0]     ctl_wdata,
  input  logic [DW-1:0]     ctl_rdata
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;
  win_e                   win;
  logic                   acc_rd;
  logic                   acc_wr;
  logic [AW-1:0]          ptr;
  logic                   ptr_load;
  logic                   ptr_step;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_sync_q <= '0;
    else
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  can_sfr_decode #(
    .SFR_AW  (SFR_AW),
    .ADR_PTR (ADR_PTR),
    .ADR_DATA(ADR_DATA),
    .ADR_MODE(ADR_MODE),
    .ADR_STAT(ADR_STAT),
    .ADR_CTRL(ADR_CTRL)
  ) u_decode (
    .sfr_addr(sfr_addr),
    .sfr_rd  (sfr_rd),
    .sfr_wr  (sfr_wr),
    .win     (win),
    .acc_rd  (acc_rd),
    .acc_wr  (acc_wr)
  );

  assign ptr_load = acc_wr & (win == WIN_PTR);
  assign ptr_step = (acc_wr | acc_rd) & (win == WIN_DATA);

  can_sfr_pointer #(
    .AW      (AW),
    .INC_BASE(INC_BASE)
  ) u_pointer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_en (ptr_load),
    .load_val(sfr_wdata[AW-1:0]),
    .step_en (ptr_step),
    .ptr     (ptr)
  );

  can_sfr_route #(
    .AW(AW),
    .DW(DW)
  ) u_route (
    .win      (win),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .ptr      (ptr),
    .sfr_wdata(sfr_wdata),
    .ctl_rdata(ctl_rdata),
    .ctl_addr (ctl_addr),
    .ctl_rd   (ctl_rd),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .sfr_rdata(sfr_rdata)
  );

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0({ctl_rd, ctl_wr})); // R12
  AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_rd && sfr_wr && sfr_addr == SFR_AW'(ADR_DATA)) |-> (ctl_wr && !ctl_rd)); // R12
  AST_NO_STROBE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_addr != SFR_AW'(ADR_DATA) && sfr_addr != SFR_AW'(ADR_MODE) &&
     sfr_addr != SFR_AW'(ADR_STAT) && sfr_addr != SFR_AW'(ADR_CTRL)) |-> (!ctl_rd && !ctl_wr)); // R11
  AST_MODE_TARGET: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((sfr_rd || sfr_wr) && sfr_addr == SFR_AW'(ADR_MODE)) |-> (ctl_addr == AW'(IREG_MODE))); // R7
  AST_STAT_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_rd && !sfr_wr && sfr_addr == SFR_AW'(ADR_STAT)) |-> (ctl_rd && ctl_addr == AW'(IREG_STATUS))); // R8
  AST_STAT_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_wr && sfr_addr == SFR_AW'(ADR_STAT)) |-> (ctl_wr && ctl_addr == AW'(IREG_IEN))); // R8
  AST_CTRL_READ_TARGET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_rd && !sfr_wr && sfr_addr == SFR_AW'(ADR_CTRL)) |-> (ctl_rd && ctl_addr == AW'(IREG_IRQ))); // R9
  AST_CTRL_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n_int)
    (sfr_wr && sfr_addr == SFR_AW'(ADR_CTRL)) |-> (ctl_wr && ctl_addr == AW'(IREG_CMD))); // R9
  AST_DATA_USES_PTR: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((sfr_rd || sfr_wr) && sfr_addr == SFR_AW'(ADR_DATA)) |-> (ctl_addr == ptr && (ctl_rd || ctl_wr))); // R3

endmodule

// File: tb/can_sfr_window_tb_top.sv
module can_sfr_window_tb_top;

  localparam logic [7:0] A_PTR  = 8'hD0;
  localparam logic [7:0] A_DATA = 8'hD1;
  localparam logic [7:0] A_MODE = 8'hD2;
  localparam logic [7:0] A_STAT = 8'hD3;
  localparam logic [7:0] A_CTRL = 8'hD4;

  logic       clk;
  logic       rst_n;
  logic [7:0] sfr_addr;
  logic       sfr_rd;
  logic       sfr_wr;
  logic [7:0] sfr_wdata;
  logic [7:0] sfr_rdata;
  logic [7:0] ctl_addr;
  logic       ctl_rd;
  logic       ctl_wr;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;

  int n_checks;
  int n_fails;

  logic [7:0] c_addr;
  logic       c_rd;
  logic       c_wr;
  logic [7:0] c_wdata;
  logic [7:0] c_rdata;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // controller register file model: contents derived from the address
  assign ctl_rdata = ctl_addr ^ 8'hA5;

  can_sfr_window dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sfr_addr (sfr_addr),
    .sfr_rd   (sfr_rd),
    .sfr_wr   (sfr_wr),
    .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .ctl_addr (ctl_addr),
    .ctl_rd   (ctl_rd),
    .ctl_wr   (ctl_wr),
    .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  // one SFR access; drive at negedge, sample mid-cycle, end on next negedge
  task automatic access(input logic [7:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    sfr_addr  = a;
    sfr_rd    = r;
    sfr_wr    = w;
    sfr_wdata = d;
    #1;
    c_addr  = ctl_addr;
    c_rd    = ctl_rd;
    c_wr    = ctl_wr;
    c_wdata = ctl_wdata;
    c_rdata = sfr_rdata;
    @(negedge clk);
    sfr_rd = 1'b0;
    sfr_wr = 1'b0;
  endtask

  task automatic ptr_set(input logic [7:0] v);
    access(A_PTR, 1'b0, 1'b1, v);
  endtask

  task automatic ptr_expect(input string req, input logic [7:0] v);
    access(A_PTR, 1'b1, 1'b0, 8'h00);
    check(req, "pointer readback", c_rdata, v);
  endtask

  task automatic t_reset;
    ptr_expect("R1", 8'h00);
  endtask

  task automatic t_pointer;
    ptr_set(8'h10);
    check("R2", "strobes on pointer write", {6'd0, c_rd, c_wr}, 8'h00);
    access(A_PTR, 1'b1, 1'b0, 8'h00);
    check("R2", "strobes on pointer read", {6'd0, c_rd, c_wr}, 8'h00);
    check("R2", "pointer read value", c_rdata, 8'h10);
  endtask

  task automatic t_low_poll;
    ptr_set(8'h03);
    for (int i = 0; i < 3; i++) begin
      access(A_DATA, 1'b1, 1'b0, 8'h00);
      check("R5", "polled address", c_addr, 8'h03);
      check("R3", "read strobe", {6'd0, c_rd, c_wr}, 8'h02);
      check("R3", "read data", c_rdata, 8'h03 ^ 8'hA5);
    end
    ptr_set(8'd31);
    access(A_DATA, 1'b0, 1'b1, 8'h77);
    check("R3", "write data", c_wdata, 8'h77);
    ptr_expect("R5", 8'd31);
  endtask

  task automatic t_upper_step;
    ptr_set(8'd32);
    access(A_DATA, 1'b1, 1'b0, 8'h00);
    check("R4", "first upper address", c_addr, 8'd32);
    access(A_DATA, 1'b1, 1'b0, 8'h00);
    check("R4", "next access uses stepped address", c_addr, 8'd33);
    ptr_expect("R4", 8'd34);
  endtask

  task automatic t_message_load;
    ptr_set(8'd112);
    for (int i = 0; i < 5; i++) begin
      access(A_DATA, 1'b0, 1'b1, 8'hC0 + 8'(i));
      check("R4", "message byte address", c_addr, 8'd112 + 8'(i));
      check("R3", "message byte data", c_wdata, 8'hC0 + 8'(i));
      check("R3", "write strobe", {6'd0, c_rd, c_wr}, 8'h01);
    end
    ptr_expect("R4", 8'd117);
  endtask

  task automatic t_wrap;
    ptr_set(8'hFF);
    access(A_DATA, 1'b0, 1'b1, 8'h11);
    check("R6", "address before wrap", c_addr, 8'hFF);
    ptr_expect("R6", 8'h00);
  endtask

  task automatic t_windows;
    ptr_set(8'd40);
    access(A_MODE, 1'b0, 1'b1, 8'h09);
    check("R7", "mode write address", c_addr, 8'h00);
    check("R7", "mode write strobe", {6'd0, c_rd, c_wr}, 8'h01);
    access(A_MODE, 1'b1, 1'b0, 8'h00);
    check("R7", "mode read address", c_addr, 8'h00);
    check("R7", "mode read data", c_rdata, 8'hA5);
    access(A_STAT, 1'b1, 1'b0, 8'h00);
    check("R8", "status read address", c_addr, 8'h02);
    check("R8", "status read data", c_rdata, 8'h02 ^ 8'hA5);
    access(A_STAT, 1'b0, 1'b1, 8'h5C);
    check("R8", "status write address", c_addr, 8'h04);
    check("R8", "status write data", c_wdata, 8'h5C);
    access(A_CTRL, 1'b1, 1'b0, 8'h00);
    check("R9", "control read address", c_addr, 8'h03);
    check("R9", "control read strobe", {6'd0, c_rd, c_wr}, 8'h02);
    access(A_CTRL, 1'b0, 1'b1, 8'h01);
    check("R9", "control write address", c_addr, 8'h01);
    check("R9", "control write strobe", {6'd0, c_rd, c_wr}, 8'h01);
    ptr_expect("R10", 8'd40);
  endtask

  task automatic t_unmapped;
    ptr_set(8'd50);
    access(8'h55, 1'b0, 1'b1, 8'hEE);
    check("R11", "strobes on unmapped write", {6'd0, c_rd, c_wr}, 8'h00);
    access(8'hD5, 1'b1, 1'b0, 8'h00);
    check("R11", "strobes on unmapped read", {6'd0, c_rd, c_wr}, 8'h00);
    check("R11", "unmapped read data", c_rdata, 8'h00);
    ptr_expect("R11", 8'd50);
  endtask

  task automatic t_both;
    ptr_set(8'd60);
    access(A_DATA, 1'b1, 1'b1, 8'h3C);
    check("R12", "combined strobe direction", {6'd0, c_rd, c_wr}, 8'h01);
    check("R12", "combined write data", c_wdata, 8'h3C);
    ptr_expect("R12", 8'd61);
    access(A_STAT, 1'b1, 1'b1, 8'h12);
    check("R12", "combined status target", c_addr, 8'h04);
  endtask

  initial begin
    #(4 * 200000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    rst_n     = 1'b0;
    sfr_addr  = 8'h00;
    sfr_rd    = 1'b0;
    sfr_wr    = 1'b0;
    sfr_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pointer();
    t_low_poll();
    t_upper_step();
    t_message_load();
    t_wrap();
    t_windows();
    t_unmapped();
    t_both();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule